// File: doc/BRIEF.md
# ECC Correction Consistency Checker with Comparator Self-Test

This block watches the single-error-correcting, double-error-detecting correction path of a wide read datapath. Each of its lanes receives the decoder syndrome, the word as read before correction and the word after correction. It raises a sticky malfunction flag when the three disagree. A zero syndrome should leave the word untouched. A nonzero syndrome should change it.

Two self-test modes check the checker itself. A keyed control write with a trigger selects a test mode and a target lane. The comparator and the zero-syndrome test then take their inputs from a software-written test word and a test checkbit value, not from the read path. In "same data" mode both comparator inputs carry the test word. In "inverted data" mode the second input carries its bitwise complement. A per-lane "compare good" flag is set when the inverted mode is entered. It drops, and stays down, as soon as any single comparator bit fails to report a difference. A per-bit fault-injection input lets a bench hold any comparator bit at "equal" to show this.

When a malfunction is flagged, the block captures the offending word, its syndrome and the read address. Software can read these captures back.

Top module: `ecc_consist_chk`

## Requirements
- R1: In functional checking (mode field not 3 or 4), each lane with `rd_valid_i` high flags a malfunction when its syndrome is zero and the pre- and post-correction words differ. It also flags one when the syndrome is nonzero and the two words are equal. The other two combinations flag nothing. The flag is visible in the cycle after the read.
- R2: Each malfunction flag is sticky. Writing 1 to its bit of `mal_clr_i` clears it. A new malfunction in the same cycle as the clear wins, and the flag stays set. Clearing one lane never touches the other.
- R3: A control write (`ctl_we_i`) takes effect only if `ctl_key_i` equals 4'b0101 and `ctl_trig_i` is 1. It then loads the 3-bit mode field and the lane select. Any other control write is ignored. Mode value 3 is "same data", 4 is "inverted data", and every other value selects functional checking.
- R4: In mode 3 the selected lane checks the test word against itself, using the test checkbit value as syndrome. A nonzero test checkbit value sets that lane's malfunction flag in the following cycle. A zero value sets nothing.
- R5: In mode 4 the selected lane checks the test word against its bitwise complement, using the test checkbit value as syndrome. A zero test checkbit value sets that lane's malfunction flag. A nonzero value sets nothing.
- R6: In modes 3 and 4, functional checking is suppressed on every lane. The read inputs never set a malfunction flag, and a lane that is not selected never flags.
- R7: An accepted write that moves the mode from any other value to 4 sets the "compare good" flag of the newly selected lane and clears the other lane's flag. `cmp_good_o` reads 0 on every lane whenever the mode is not 4.
- R8: In mode 4, if any comparator bit of the selected lane reports "equal", that lane's good flag clears at the next edge. It stays clear until mode 4 is entered again from another mode. Setting bit i of a lane's slice of `cmp_stuck_i` forces comparator bit i of that lane to "equal".
- R9: An accepted write that keeps the mode at 4 but changes the lane select does not set the newly selected lane's good flag.
- R10: On any malfunction, the capture registers load at the next edge: `raw_data_o` takes the lowest-numbered flagging lane's comparator input word, `raw_chk_o` takes its syndrome, and `err_addr_o` takes `rd_addr_i`. This also happens in modes 3 and 4, where the captured word and syndrome are the test values themselves.
- R11: `raw_we_i` writes the test word and test checkbit value at the next edge. It takes priority over a simultaneous capture of word and syndrome. The address capture is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid_i | input | 1 | A read word is present on the lane inputs |
| rd_addr_i | input | ADDR_W (20) | Address of the current read |
| rd_syn_i | input | LANES*SYN_W (16) | Decoder syndrome, lane i at bits [i*SYN_W +: SYN_W] |
| rd_pre_i | input | LANES*DATA_W (128) | Words before correction |
| rd_post_i | input | LANES*DATA_W (128) | Words after correction |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_key_i | input | 4 | Diagnostic key, must be 4'b0101 |
| ctl_trig_i | input | 1 | Diagnostic trigger, must be 1 |
| ctl_mode_i | input | 3 | Mode field (3 same data, 4 inverted data) |
| ctl_lane_i | input | LSEL_W (1) | Lane targeted by the test modes |
| raw_we_i | input | 1 | Test word / checkbit write strobe |
| raw_data_wd_i | input | DATA_W (64) | Test word to write |
| raw_chk_wd_i | input | SYN_W (8) | Test checkbit value to write |
| mal_clr_i | input | LANES (2) | Per-lane write-one-to-clear for malfunction flags |
| cmp_stuck_i | input | LANES*DATA_W (128) | Per-bit comparator fault injection, 1 forces "equal" |
| mal_err_o | output | LANES (2) | Sticky malfunction flags |
| cmp_good_o | output | LANES (2) | Compare-good flags, valid in mode 4 only |
| raw_data_o | output | DATA_W (64) | Test word / captured word |
| raw_chk_o | output | SYN_W (8) | Test checkbit value / captured syndrome |
| err_addr_o | output | ADDR_W (20) | Address captured on a malfunction |

## Verification
The functional-path properties take for granted that `cmp_stuck_i` is all zero, because an injected fault legitimately changes what the comparator reports. The bench therefore raises fault bits only in the inverted-mode sweep that targets the good flag. The lane select is assumed to name an existing lane, and control and test-word writes are assumed to be single-cycle strobes. Every control write the bench issues uses lane 0 or 1 and one-cycle pulses. The stimulus walks every key and trigger combination, every test checkbit value in both test modes, and every single comparator bit as a stuck fault on each lane.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;

  localparam int MODE_W = 3;
  localparam int KEY_W  = 4;
  localparam logic [KEY_W-1:0]  DIAG_KEY  = 4'b0101;
  localparam logic [MODE_W-1:0] MODE_SAME = 3'd3;
  localparam logic [MODE_W-1:0] MODE_INV  = 3'd4;

  typedef enum logic [1:0] {
    K_FUNC = 2'd0,
    K_SAME = 2'd1,
    K_INV  = 2'd2
  } chk_kind_e;

  // Decode the raw mode field into the kind of checking performed.
  function automatic chk_kind_e f_kind(input logic [MODE_W-1:0] m);
    if (m == MODE_SAME) return K_SAME;
    if (m == MODE_INV)  return K_INV;
    return K_FUNC;
  endfunction

  // Consistency rule: nonzero syndrome needs a change, zero syndrome forbids one.
  function automatic logic f_mal(input logic syn_nz, input logic any_diff);
    return syn_nz ? !any_diff : any_diff;
  endfunction

endpackage

// File: rtl/ecc_chk_ctrl.sv
module ecc_chk_ctrl
  import ecc_chk_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LSEL_W = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [KEY_W-1:0]      key_i,
  input  logic                  trig_i,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic [LSEL_W-1:0]     lane_i,
  output chk_kind_e             kind_o,
  output logic [LANES-1:0]      sel_o,
  output logic [LANES-1:0]      enter_me_o,
  output logic                  enter_any_o
);

  logic [MODE_W-1:0] mode_q;
  logic [LSEL_W-1:0] lane_q;
  logic              acc;

  assign acc = we_i && trig_i && (key_i == DIAG_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      lane_q <= '0;
    end else if (acc) begin
      mode_q <= mode_i;
      lane_q <= lane_i;
    end
  end

  assign kind_o      = f_kind(mode_q);
  assign enter_any_o = acc && (f_kind(mode_i) == K_INV) && (f_kind(mode_q) != K_INV);

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      sel_o[i]      = (lane_q == LSEL_W'(i));
      enter_me_o[i] = enter_any_o && (lane_i == LSEL_W'(i));
    end
  end

  // R3: without an accepted write the mode and lane hold
  p_mode_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(mode_q) && $stable(lane_q)));

endmodule

// File: rtl/ecc_chk_lane.sv
module ecc_chk_lane
  import ecc_chk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  chk_kind_e         kind_i,
  input  logic              sel_i,
  input  logic              enter_me_i,
  input  logic              enter_any_i,
  input  logic              rd_valid_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  logic [DATA_W-1:0] pre_i,
  input  logic [DATA_W-1:0] post_i,
  input  logic [DATA_W-1:0] raw_data_i,
  input  logic [SYN_W-1:0]  raw_chk_i,
  input  logic [DATA_W-1:0] stuck_i,
  input  logic              clr_i,
  output logic              err_o,
  output logic              mal_o,
  output logic              good_o,
  output logic [DATA_W-1:0] cap_data_o,
  output logic [SYN_W-1:0]  cap_syn_o
);

  logic              diag;
  logic [DATA_W-1:0] cmp_a, cmp_b, diff;
  logic [SYN_W-1:0]  syn_use;
  logic              any_diff, all_diff, syn_nz, chk_en;
  logic              mal_q, good_q;

  assign diag    = (kind_i != K_FUNC);
  assign cmp_a   = diag ? raw_data_i : pre_i;
  assign cmp_b   = !diag ? post_i : ((kind_i == K_INV) ? ~raw_data_i : raw_data_i);
  assign syn_use = diag ? raw_chk_i : syn_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign diff[b] = (cmp_a[b] ^ cmp_b[b]) & ~stuck_i[b];
  end

  assign any_diff = |diff;
  assign all_diff = &diff;
  assign syn_nz   = |syn_use;
  assign chk_en   = diag ? sel_i : rd_valid_i;
  assign err_o    = chk_en && f_mal(syn_nz, any_diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mal_q <= 1'b0;
    else if (err_o)  mal_q <= 1'b1;
    else if (clr_i)  mal_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               good_q <= 1'b0;
    else if (enter_me_i)                      good_q <= 1'b1;
    else if (enter_any_i)                     good_q <= 1'b0;
    else if (kind_i != K_INV)                 good_q <= 1'b0;
    else if (sel_i && !all_diff)              good_q <= 1'b0;
  end

  assign mal_o      = mal_q;
  assign good_o     = good_q && (kind_i == K_INV);
  assign cap_data_o = cmp_a;
  assign cap_syn_o  = syn_use;

  // R1: zero syndrome with a changed word is a malfunction
  p_func_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag && rd_valid_i && (syn_i == '0) && (pre_i != post_i) && (stuck_i == '0)) |=> mal_q);
  // R2: flag stays set unless cleared
  p_mal_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mal_q && !clr_i) |=> mal_q);
  p_mal_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> mal_q);
  // R4: same-data mode with nonzero checkbits must flag
  p_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_SAME && sel_i && raw_chk_i != '0) |=> mal_q);
  // R5: inverted-data mode with zero checkbits must flag
  p_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_INV && sel_i && raw_chk_i == '0 && stuck_i == '0) |=> mal_q);
  // R6: unselected lane in a test mode never reports
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (diag && !sel_i) |-> !err_o);
  // R7, R9: good flag rises only on entry into mode 4 for this lane
  p_good_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_q) |-> $past(enter_me_i));
  // R8: once low, good stays low until re-entry
  p_good_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!good_q && !enter_me_i) |=> !good_q);
  p_good_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (good_q && kind_i == K_INV && sel_i && !all_diff && !enter_any_i) |=> !good_q);

endmodule

// File: rtl/ecc_chk_capture.sv
module ecc_chk_capture #(
  parameter int LANES  = 2,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 8,
  parameter int ADDR_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          err_vec_i,
  input  logic [LANES*DATA_W-1:0]   cap_data_i,
  input  logic [LANES*SYN_W-1:0]    cap_syn_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  input  logic                      sw_we_i,
  input  logic [DATA_W-1:0]         sw_data_i,
  input  logic [SYN_W-1:0]          sw_chk_i,
  output logic [DATA_W-1:0]         raw_data_o,
  output logic [SYN_W-1:0]          raw_chk_o,
  output logic [ADDR_W-1:0]         err_addr_o
);

  logic [DATA_W-1:0] sel_d;
  logic [SYN_W-1:0]  sel_s;
  logic              hit;
  logic [DATA_W-1:0] data_q;
  logic [SYN_W-1:0]  chk_q;
  logic [ADDR_W-1:0] addr_q;

  // Lowest-numbered flagging lane wins: scan downwards, last hit stays.
  always_comb begin
    sel_d = '0;
    sel_s = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (err_vec_i[i]) begin
        sel_d = cap_data_i[i*DATA_W +: DATA_W];
        sel_s = cap_syn_i[i*SYN_W +: SYN_W];
      end
    end
  end

  assign hit = |err_vec_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      chk_q  <= '0;
    end else if (sw_we_i) begin
      data_q <= sw_data_i;
      chk_q  <= sw_chk_i;
    end else if (hit) begin
      data_q <= sel_d;
      chk_q  <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (hit) addr_q <= rd_addr_i;
  end

  assign raw_data_o = data_q;
  assign raw_chk_o  = chk_q;
  assign err_addr_o = addr_q;

  // R10: capture of the flagging lane's word, syndrome and address
  p_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !sw_we_i) |=> (data_q == $past(sel_d)) && (chk_q == $past(sel_s)));
  p_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (addr_q == $past(rd_addr_i)));
  // R11: software write wins
  p_sw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we_i |=> (data_q == $past(sw_data_i)) && (chk_q == $past(sw_chk_i)));

endmodule

// File: rtl/ecc_consist_chk.sv
module ecc_consist_chk
  import ecc_chk_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 8,
  parameter int ADDR_W = 20,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [LANES*SYN_W-1:0]  rd_syn_i,
  input  logic [LANES*DATA_W-1:0] rd_pre_i,
  input  logic [LANES*DATA_W-1:0] rd_post_i,
  input  logic                    ctl_we_i,
  input  logic [KEY_W-1:0]        ctl_key_i,
  input  logic                    ctl_trig_i,
  input  logic [MODE_W-1:0]       ctl_mode_i,
  input  logic [LSEL_W-1:0]       ctl_lane_i,
  input  logic                    raw_we_i,
  input  logic [DATA_W-1:0]       raw_data_wd_i,
  input  logic [SYN_W-1:0]        raw_chk_wd_i,
  input  logic [LANES-1:0]        mal_clr_i,
  input  logic [LANES*DATA_W-1:0] cmp_stuck_i,
  output logic [LANES-1:0]        mal_err_o,
  output logic [LANES-1:0]        cmp_good_o,
  output logic [DATA_W-1:0]       raw_data_o,
  output logic [SYN_W-1:0]        raw_chk_o,
  output logic [ADDR_W-1:0]       err_addr_o
);

  chk_kind_e               kind;
  logic [LANES-1:0]        sel, enter_me, err_vec;
  logic                    enter_any;
  logic [LANES*DATA_W-1:0] cap_data;
  logic [LANES*SYN_W-1:0]  cap_syn;

  ecc_chk_ctrl #(.LANES(LANES), .LSEL_W(LSEL_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (ctl_we_i),
    .key_i      (ctl_key_i),
    .trig_i     (ctl_trig_i),
    .mode_i     (ctl_mode_i),
    .lane_i     (ctl_lane_i),
    .kind_o     (kind),
    .sel_o      (sel),
    .enter_me_o (enter_me),
    .enter_any_o(enter_any)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ecc_chk_lane #(.DATA_W(DATA_W), .SYN_W(SYN_W)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind_i     (kind),
      .sel_i      (sel[i]),
      .enter_me_i (enter_me[i]),
      .enter_any_i(enter_any),
      .rd_valid_i (rd_valid_i),
      .syn_i      (rd_syn_i[i*SYN_W +: SYN_W]),
      .pre_i      (rd_pre_i[i*DATA_W +: DATA_W]),
      .post_i     (rd_post_i[i*DATA_W +: DATA_W]),
      .raw_data_i (raw_data_o),
      .raw_chk_i  (raw_chk_o),
      .stuck_i    (cmp_stuck_i[i*DATA_W +: DATA_W]),
      .clr_i      (mal_clr_i[i]),
      .err_o      (err_vec[i]),
      .mal_o      (mal_err_o[i]),
      .good_o     (cmp_good_o[i]),
      .cap_data_o (cap_data[i*DATA_W +: DATA_W]),
      .cap_syn_o  (cap_syn[i*SYN_W +: SYN_W])
    );
  end

  ecc_chk_capture #(.LANES(LANES), .DATA_W(DATA_W), .SYN_W(SYN_W), .ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_vec_i (err_vec),
    .cap_data_i(cap_data),
    .cap_syn_i (cap_syn),
    .rd_addr_i (rd_addr_i),
    .sw_we_i   (raw_we_i),
    .sw_data_i (raw_data_wd_i),
    .sw_chk_i  (raw_chk_wd_i),
    .raw_data_o(raw_data_o),
    .raw_chk_o (raw_chk_o),
    .err_addr_o(err_addr_o)
  );

  // R7: at most one lane may report compare-good at a time
  p_good_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_good_o));

endmodule

// File: tb/ecc_consist_chk_tb.sv
`timescale 1ns/1ps
module ecc_consist_chk_tb;

  localparam int NL = 2;
  localparam int DW = 64;
  localparam int SW = 8;
  localparam int AW = 20;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rd_valid = 1'b0;
  logic [AW-1:0]   rd_addr = '0;
  logic [NL*SW-1:0] rd_syn = '0;
  logic [NL*DW-1:0] rd_pre = '0, rd_post = '0;
  logic            ctl_we = 1'b0, ctl_trig = 1'b0;
  logic [3:0]      ctl_key = '0;
  logic [2:0]      ctl_mode = '0;
  logic            ctl_lane = 1'b0;
  logic            raw_we = 1'b0;
  logic [DW-1:0]   raw_d = '0;
  logic [SW-1:0]   raw_c = '0;
  logic [NL-1:0]   mal_clr = '0;
  logic [NL*DW-1:0] stuck = '0;
  logic [NL-1:0]   mal, good;
  logic [DW-1:0]   raw_data;
  logic [SW-1:0]   raw_chk;
  logic [AW-1:0]   err_addr;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ecc_consist_chk #(.LANES(NL), .DATA_W(DW), .SYN_W(SW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .rd_syn_i(rd_syn), .rd_pre_i(rd_pre), .rd_post_i(rd_post),
    .ctl_we_i(ctl_we), .ctl_key_i(ctl_key), .ctl_trig_i(ctl_trig),
    .ctl_mode_i(ctl_mode), .ctl_lane_i(ctl_lane),
    .raw_we_i(raw_we), .raw_data_wd_i(raw_d), .raw_chk_wd_i(raw_c),
    .mal_clr_i(mal_clr), .cmp_stuck_i(stuck),
    .mal_err_o(mal), .cmp_good_o(good), .raw_data_o(raw_data),
    .raw_chk_o(raw_chk), .err_addr_o(err_addr)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic ctl_wr(input logic [3:0] k, input logic t, input logic [2:0] m, input logic l);
    ctl_we = 1'b1; ctl_key = k; ctl_trig = t; ctl_mode = m; ctl_lane = l;
    step();
    ctl_we = 1'b0; ctl_trig = 1'b0;
  endtask

  task automatic raw_wr(input logic [DW-1:0] d, input logic [SW-1:0] c);
    raw_we = 1'b1; raw_d = d; raw_c = c;
    step();
    raw_we = 1'b0;
  endtask

  task automatic clr_all();
    rd_valid = 1'b0; mal_clr = '1;
    step();
    mal_clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] pat;
    logic [SW-1:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // reset state
    chk("R2 reset flags", DW'(mal), '0);
    chk("R7 reset good", DW'(good), '0);
    chk("R10 reset capture", raw_data, '0);
    chk("R10 reset addr", DW'(err_addr), '0);

    // R1 sweep: every bit flip, zero/nonzero syndrome, equal/differ, both lanes
    for (int ln = 0; ln < NL; ln++) begin
      for (int b = 0; b < DW; b++) begin
        for (int sz = 0; sz < 2; sz++) begin
          for (int eq = 0; eq < 2; eq++) begin
            logic expm;
            pat = {32'hC3A5_5A3C ^ 32'(b), 32'(b * 977 + ln)};
            s = sz ? SW'(b + 1) : '0;
            rd_pre = {pat ^ 64'h1111, pat ^ 64'h1111};
            rd_post = rd_pre;
            rd_syn = '0;
            rd_pre[ln*DW +: DW] = pat;
            rd_post[ln*DW +: DW] = eq ? pat : (pat ^ (64'd1 << b));
            rd_syn[ln*SW +: SW] = s;
            rd_addr = AW'(b * 4 + ln);
            rd_valid = 1'b1;
            step();
            expm = sz ? (eq != 0) : (eq == 0);
            chk("R1 flag", DW'(mal[ln]), DW'(expm));
            chk("R1 other lane quiet", DW'(mal[1-ln]), '0);
            if (expm) begin
              chk("R10 captured word", raw_data, pat);
              chk("R10 captured syndrome", DW'(raw_chk), DW'(s));
              chk("R10 captured addr", DW'(err_addr), DW'(AW'(b * 4 + ln)));
            end
            clr_all();
            chk("R2 cleared", DW'(mal), '0);
          end
        end
      end
    end

    // R2 stickiness, per-lane clear, set beats clear
    rd_pre = '0; rd_post = '0; rd_syn = '0;
    rd_post[0] = 1'b1; rd_post[DW] = 1'b1;
    rd_valid = 1'b1; step(); rd_valid = 1'b0;
    step(); step();
    chk("R2 sticky both", DW'(mal), 64'd3);
    mal_clr = 2'b10; step(); mal_clr = '0;
    chk("R2 clear lane1 only", DW'(mal), 64'd1);
    rd_valid = 1'b1; mal_clr = 2'b01; step(); mal_clr = '0; rd_valid = 1'b0;
    chk("R2 set wins over clear", DW'(mal), 64'd3);
    clr_all();

    // R10 lowest lane priority
    rd_pre = {64'hBBBB_0000_BBBB_0000, 64'hAAAA_0000_AAAA_0000};
    rd_post = rd_pre; rd_syn = {8'h22, 8'h11}; rd_addr = 20'h12345;
    rd_valid = 1'b1; step(); rd_valid = 1'b0;
    chk("R10 lane0 priority word", raw_data, 64'hAAAA_0000_AAAA_0000);
    chk("R10 lane0 priority syn", DW'(raw_chk), 64'h11);
    chk("R10 addr", DW'(err_addr), 64'h12345);
    rd_syn = {8'h22, 8'h00}; rd_valid = 1'b1; step(); rd_valid = 1'b0;
    chk("R10 lane1 word", raw_data, 64'hBBBB_0000_BBBB_0000);
    clr_all();

    // R11 software write, and its priority over a capture
    raw_wr(64'h0123_4567_89AB_CDEF, 8'h5A);
    chk("R11 write word", raw_data, 64'h0123_4567_89AB_CDEF);
    chk("R11 write chk", DW'(raw_chk), 64'h5A);
    rd_valid = 1'b1; rd_addr = 20'h00777;
    raw_wr(64'hFEDC_BA98_7654_3210, 8'h3C); rd_valid = 1'b0;
    chk("R11 write beats capture", raw_data, 64'hFEDC_BA98_7654_3210);
    chk("R10 addr still captured", DW'(err_addr), 64'h00777);
    clr_all();

    // R3 key and trigger sweep, observed through the good flag
    for (int k = 0; k < 16; k++) begin
      for (int t = 0; t < 2; t++) begin
        logic ok;
        ok = (k == 5) && (t == 1);
        ctl_wr(4'(k), t[0], 3'd4, 1'b0);
        chk("R3 keyed entry", DW'(good[0]), DW'(ok));
        if (ok) begin
          ctl_wr(4'b0101, 1'b1, 3'd0, 1'b0);
          chk("R7 good zero outside mode 4", DW'(good), '0);
        end
      end
    end

    // R4 / R5 / R6: checkbit sweep in both test modes on both lanes
    for (int md = 3; md <= 4; md++) begin
      for (int ln = 0; ln < NL; ln++) begin
        rd_valid = 1'b1; rd_syn = '0; rd_pre = '0; rd_post = '1;
        ctl_wr(4'b0101, 1'b1, 3'(md), ln[0]);
        for (int c = 0; c < 256; c++) begin
          logic expm;
          pat = {8{8'(c) ^ 8'h3C}};
          rd_addr = AW'(c + md * 1000);
          raw_wr(pat, (md == 3) ? 8'h00 : 8'h01);
          clr_all(); rd_valid = 1'b1;
          chk("R6 cleared in test mode", DW'(mal), '0);
          raw_wr(pat, 8'(c));
          step();
          expm = (md == 3) ? (c != 0) : (c == 0);
          chk(md == 3 ? "R4 same-data flag" : "R5 inverted flag", DW'(mal[ln]), DW'(expm));
          chk("R6 other lane quiet", DW'(mal[1-ln]), '0);
          chk("R10 test word kept", raw_data, pat);
          if (expm) chk("R10 addr in test mode", DW'(err_addr), DW'(AW'(c + md * 1000)));
          if (md == 4) begin
            chk("R7 good on selected", DW'(good[ln]), 64'd1);
            chk("R7 good off other", DW'(good[1-ln]), '0);
          end else begin
            chk("R7 good zero in mode 3", DW'(good), '0);
          end
        end
        ctl_wr(4'b0101, 1'b1, 3'd0, 1'b0);
        clr_all();
      end
    end

    // R8 stuck-bit sweep over every comparator bit of each lane
    for (int ln = 0; ln < NL; ln++) begin
      for (int b = 0; b < DW; b++) begin
        raw_wr(64'hA5A5_5A5A_0F0F_F0F0 ^ (64'd1 << b), 8'h01);
        stuck = '0; stuck[ln*DW + b] = 1'b1;
        ctl_wr(4'b0101, 1'b1, 3'd4, ln[0]);
        chk("R7 good set on entry", DW'(good[ln]), 64'd1);
        step();
        chk("R8 good cleared by stuck bit", DW'(good[ln]), '0);
        stuck = '0; step();
        chk("R8 good stays low", DW'(good[ln]), '0);
        ctl_wr(4'b0101, 1'b1, 3'd4, ln[0]);
        chk("R8 rewrite in mode 4 no re-set", DW'(good[ln]), '0);
        ctl_wr(4'b0101, 1'b1, 3'd0, 1'b0);
        chk("R7 zero after exit", DW'(good), '0);
      end
    end
    clr_all();

    // R9 lane change inside mode 4
    ctl_wr(4'b0101, 1'b1, 3'd4, 1'b0);
    chk("R9 lane0 good", DW'(good[0]), 64'd1);
    ctl_wr(4'b0101, 1'b1, 3'd4, 1'b1);
    chk("R9 lane1 not set by select change", DW'(good[1]), '0);
    ctl_wr(4'b0101, 1'b1, 3'd3, 1'b1);
    ctl_wr(4'b0101, 1'b1, 3'd4, 1'b1);
    chk("R9 entry from mode 3 sets lane1", DW'(good[1]), 64'd1);
    chk("R7 entry clears lane0", DW'(good[0]), '0);
    ctl_wr(4'b0101, 1'b1, 3'd0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule